// File: doc/BRIEF.md
# Host-Fed Monochrome and Colour Pixel Expander

This block sits between a host register port and a downstream pixel writer in a 2D drawing engine. The host programs a rectangle size, a destination origin, a pixel format and two colours. It then writes a command word that starts a transfer whose source data comes from the host. No memory is read. The host then pushes 32-bit source words into a data-port register. The block unpacks each word into pixels and sends them out in raster order with absolute destination coordinates, over a valid/ready stream.

There are two modes. In monochrome expansion each source bit becomes one pixel, coloured with the foreground value when the bit is 1 and the background value when it is 0. In colour copy each pixel is taken directly from 1, 2 or 4 bytes of the word. The number of data-port words that the block expects is fixed by a rounding rule over width, height and bytes per source pixel. The block signals completion once it has received that many words and the last pixel has left its output. Writes beyond that count are swallowed and flagged. The data port is stalled while the block cannot take another word.

Top module: `hx_expander`

## Requirements
- R1: After reset, busy, done, excess and pix_valid are low, and reg_ready is high. reg_ready is always high when reg_addr is not the data port (address 6).
- R2: A write to the command register (address 0) starts a transfer only if bit 6 (host source) is set and a mode is selected. Monochrome is selected when bits 1, 8 and 17 are all set. Colour copy is selected when bit 0 is set and the monochrome triple is not complete. Any other command leaves the block idle.
- R3: In monochrome mode, bits are taken from each data word starting at bit 31. A 1 gives the foreground colour (address 2) and a 0 gives the background colour (address 3). Pixels continue from word to word with no padding at row ends.
- R4: In colour copy, the format register (address 4) bits [1:0] set the bytes per pixel: 0 gives 1 byte, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Pixels are taken from the least significant lane of the word first and zero-extended to 32 bits.
- R5: Pixels leave in raster order. pix_x equals origin x (address 5, bits [11:0]) plus the column, and pix_y equals origin y (address 5, bits [27:16]) plus the row. Both wrap modulo 4096.
- R6: The size register (address 1) holds width-1 in bits [11:0] and height-1 in bits [27:16].
- R7: A transfer expects exactly (width*height*B+3)/4 data-port words, where B is 1 in monochrome mode and the bytes per pixel in colour copy. Words received after all pixels have been formed are accepted and produce no pixel.
- R8: done is high for exactly one cycle, in the first cycle that busy is low after a transfer. busy falls only after all expected words have arrived and the last pixel has been taken downstream.
- R9: A data-port write made while idle, or after the expected word count has been reached, is accepted and produces no pixel. excess is high in the cycle after it.
- R10: While pix_valid is high and pix_ready is low, the pixel outputs hold. A data-port write is refused (reg_ready low) while the held word still has pixels that cannot advance. No word and no pixel is lost.
- R11: A command written during a transfer is ignored.
- R12: Size, origin, format and colour values are captured when a transfer starts. Register writes made during a transfer do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 command, 1 size, 2 foreground, 3 background, 4 format, 5 origin, 6 data port) |
| reg_wdata | input | 32 | Register write data |
| reg_ready | output | 1 | Write accepted this cycle (only ever low for the data port) |
| pix_valid | output | 1 | Output pixel present |
| pix_ready | input | 1 | Downstream accepts the pixel |
| pix_x | output | 12 | Destination x of the pixel |
| pix_y | output | 12 | Destination y of the pixel |
| pix_color | output | 32 | Pixel value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| excess | output | 1 | One-cycle flag for a surplus data-port write |

## Verification
The two functions that can fall in the same cycle are unpacking the last pixel of a held word into the output queue and loading the next data-port word into the now-free holding register. The bench provokes this by feeding words back to back while pix_ready follows a one-in-three pattern, so the queue fills and drains at shifting phases against the word boundaries. Every pixel is compared in order against colours and coordinates computed from the data words, so a lost or doubled word shows up as a wrong value or a wrong count. A stall test holds the output for many cycles and checks that the data port refuses, that the outputs are stable, and that a late command and a colour change have no effect on the transfer.

// File: rtl/hx_pkg.sv
package hx_pkg;

    // register map of the write port
    localparam logic [2:0] ADDR_CMD  = 3'd0;
    localparam logic [2:0] ADDR_SIZE = 3'd1;
    localparam logic [2:0] ADDR_FG   = 3'd2;
    localparam logic [2:0] ADDR_BG   = 3'd3;
    localparam logic [2:0] ADDR_FMT  = 3'd4;
    localparam logic [2:0] ADDR_ORG  = 3'd5;
    localparam logic [2:0] ADDR_DATA = 3'd6;

    // command word bit positions
    localparam int CMD_COPY  = 0;
    localparam int CMD_MONO0 = 1;
    localparam int CMD_HOST  = 6;
    localparam int CMD_MONO1 = 8;
    localparam int CMD_MONO2 = 17;

    // offset of the second coordinate in size and origin words
    localparam int HI_OFS = 16;

    // format code to log2(bytes per pixel)
    function automatic logic [1:0] fmt_to_lg(input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/hx_regfile.sv
module hx_regfile
    import hx_pkg::*;
#(
    parameter int CW   = 12,
    parameter int DW   = 32,
    parameter int CNTW = 2 * CW + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr,
    input  logic [2:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    input  logic            busy,
    output logic            start,
    output logic            job_mono,
    output logic [1:0]      job_lg,
    output logic [CW-1:0]   job_wm1,
    output logic [CW-1:0]   job_ox,
    output logic [CW-1:0]   job_oy,
    output logic [DW-1:0]   job_fg,
    output logic [DW-1:0]   job_bg,
    output logic [CNTW-1:0] job_words,
    output logic [CNTW-1:0] job_pix
);

    typedef struct packed {
        logic [CW-1:0] wm1;
        logic [CW-1:0] hm1;
        logic [CW-1:0] ox;
        logic [CW-1:0] oy;
        logic [DW-1:0] fg;
        logic [DW-1:0] bg;
        logic [1:0]    fmt;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic          is_host, is_mono, is_copy;
    logic [CW:0]   w_ext, h_ext;
    logic [CNTW-1:0] pix_cnt, byte_cnt;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_SIZE: begin
                    cfg_d.wm1 = reg_wdata[CW-1:0];
                    cfg_d.hm1 = reg_wdata[HI_OFS +: CW];
                end
                ADDR_FG:  cfg_d.fg  = reg_wdata;
                ADDR_BG:  cfg_d.bg  = reg_wdata;
                ADDR_FMT: cfg_d.fmt = reg_wdata[1:0];
                ADDR_ORG: begin
                    cfg_d.ox = reg_wdata[CW-1:0];
                    cfg_d.oy = reg_wdata[HI_OFS +: CW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // command decode
    always_comb begin
        is_host = reg_wdata[CMD_HOST];
        is_mono = reg_wdata[CMD_MONO0] & reg_wdata[CMD_MONO1] & reg_wdata[CMD_MONO2];
        is_copy = reg_wdata[CMD_COPY];
        start   = reg_wr && (reg_addr == ADDR_CMD) && !busy && is_host && (is_mono || is_copy);
    end

    // job parameters and expected word count
    always_comb begin
        w_ext     = {1'b0, cfg_q.wm1} + 1'b1;
        h_ext     = {1'b0, cfg_q.hm1} + 1'b1;
        pix_cnt   = CNTW'(w_ext) * CNTW'(h_ext);
        job_lg    = fmt_to_lg(cfg_q.fmt);
        job_mono  = is_mono;
        byte_cnt  = is_mono ? pix_cnt : (pix_cnt << job_lg);
        job_words = (byte_cnt + CNTW'(3)) >> 2;
        job_pix   = pix_cnt;
        job_wm1   = cfg_q.wm1;
        job_ox    = cfg_q.ox;
        job_oy    = cfg_q.oy;
        job_fg    = cfg_q.fg;
        job_bg    = cfg_q.bg;
    end

endmodule

// File: rtl/hx_unpack.sv
module hx_unpack #(
    parameter int CW   = 12,
    parameter int DW   = 32,
    parameter int CNTW = 2 * CW + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            job_mono,
    input  logic [1:0]      job_lg,
    input  logic [CW-1:0]   job_wm1,
    input  logic [CW-1:0]   job_ox,
    input  logic [CW-1:0]   job_oy,
    input  logic [DW-1:0]   job_fg,
    input  logic [DW-1:0]   job_bg,
    input  logic [CNTW-1:0] job_words,
    input  logic [CNTW-1:0] job_pix,
    input  logic            dp_wr,
    input  logic [DW-1:0]   dp_data,
    input  logic            fifo_full,
    input  logic            fifo_empty,
    output logic            dp_ready,
    output logic            push,
    output logic [CW-1:0]   push_x,
    output logic [CW-1:0]   push_y,
    output logic [DW-1:0]   push_color,
    output logic            busy,
    output logic            done,
    output logic            excess
);

    localparam int IW    = $clog2(DW);
    localparam int LANES = DW / 8;

    typedef struct packed {
        logic            busy;
        logic            mono;
        logic [1:0]      lg;
        logic [CW-1:0]   wm1;
        logic [CW-1:0]   ox;
        logic [CW-1:0]   oy;
        logic [DW-1:0]   fg;
        logic [DW-1:0]   bg;
        logic [CNTW-1:0] wleft;
        logic [CNTW-1:0] pleft;
        logic [DW-1:0]   wbuf;
        logic            wval;
        logic [IW-1:0]   idx;
        logic [CW-1:0]   cx;
        logic [CW-1:0]   cy;
        logic            done;
        logic            excess;
    } st_t;

    st_t q, d;

    logic [IW:0]   ppw;
    logic          last_in_word;
    logic          can_emit;
    logic          accept;
    logic [IW+2:0] sh;
    logic [DW-1:0] shifted;
    logic [DW-1:0] lane_val;
    logic          mono_bit;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        d.excess = 1'b0;

        // pixels per word and extraction of the current pixel
        ppw          = q.mono ? (IW+1)'(DW) : (IW+1)'(LANES >> q.lg);
        last_in_word = ({1'b0, q.idx} == ppw - 1'b1) || (q.pleft == CNTW'(1));
        sh           = {q.idx, 3'b000} << q.lg;
        shifted      = q.wbuf >> sh;
        case (q.lg)
            2'd0:    lane_val = DW'(shifted[7:0]);
            2'd1:    lane_val = DW'(shifted[15:0]);
            default: lane_val = shifted;
        endcase
        mono_bit   = q.wbuf[IW'(DW-1) - q.idx];
        push_color = q.mono ? (mono_bit ? q.fg : q.bg) : lane_val;
        push_x     = q.ox + q.cx;
        push_y     = q.oy + q.cy;

        can_emit = q.busy && q.wval && !fifo_full;
        push     = can_emit;
        dp_ready = !q.busy || (q.wleft == '0) || !q.wval || (can_emit && last_in_word);
        accept   = dp_wr && dp_ready;

        // emit one pixel into the queue
        if (can_emit) begin
            d.pleft = q.pleft - 1'b1;
            if (q.cx == q.wm1) begin
                d.cx = '0;
                d.cy = q.cy + 1'b1;
            end else begin
                d.cx = q.cx + 1'b1;
            end
            if (last_in_word) begin
                d.wval = 1'b0;
                d.idx  = '0;
            end else begin
                d.idx = q.idx + 1'b1;
            end
        end

        // take a data-port word
        if (accept) begin
            if (q.busy && (q.wleft != '0)) begin
                d.wleft = q.wleft - 1'b1;
                if (d.pleft != '0) begin
                    d.wbuf = dp_data;
                    d.wval = 1'b1;
                    d.idx  = '0;
                end
            end else begin
                d.excess = 1'b1;
            end
        end

        // completion
        if (q.busy && (q.wleft == '0) && (q.pleft == '0) && fifo_empty) begin
            d.busy = 1'b0;
            d.done = 1'b1;
        end

        // start of a new transfer
        if (start && !q.busy) begin
            d.busy  = 1'b1;
            d.mono  = job_mono;
            d.lg    = job_lg;
            d.wm1   = job_wm1;
            d.ox    = job_ox;
            d.oy    = job_oy;
            d.fg    = job_fg;
            d.bg    = job_bg;
            d.wleft = job_words;
            d.pleft = job_pix;
            d.wval  = 1'b0;
            d.idx   = '0;
            d.cx    = '0;
            d.cy    = '0;
        end

        busy   = q.busy;
        done   = q.done;
        excess = q.excess;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/hx_pix_fifo.sv
module hx_pix_fifo #(
    parameter int W     = 56,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [NW-1:0] cnt;
    } ptr_t;

    ptr_t q, d;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        d       = q;
        full    = (q.cnt == NW'(DEPTH));
        empty   = (q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (do_push) d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        if (do_pop)  d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        dout = mem[q.rp];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wp] <= din;
    end

endmodule

// File: rtl/hx_expander.sv
module hx_expander
    import hx_pkg::*;
#(
    parameter int CW    = 12,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic          reg_ready,
    output logic          pix_valid,
    input  logic          pix_ready,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] pix_y,
    output logic [DW-1:0] pix_color,
    output logic          busy,
    output logic          done,
    output logic          excess
);

    localparam int CNTW = 2 * CW + 4;
    localparam int PW   = 2 * CW + DW;

    logic            start, job_mono;
    logic [1:0]      job_lg;
    logic [CW-1:0]   job_wm1, job_ox, job_oy;
    logic [DW-1:0]   job_fg, job_bg;
    logic [CNTW-1:0] job_words, job_pix;
    logic            dp_wr, dp_ready;
    logic            push, fifo_full, fifo_empty;
    logic [CW-1:0]   push_x, push_y;
    logic [DW-1:0]   push_color;
    logic [PW-1:0]   fifo_out;

    hx_regfile #(.CW(CW), .DW(DW), .CNTW(CNTW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy),
        .start     (start),
        .job_mono  (job_mono),
        .job_lg    (job_lg),
        .job_wm1   (job_wm1),
        .job_ox    (job_ox),
        .job_oy    (job_oy),
        .job_fg    (job_fg),
        .job_bg    (job_bg),
        .job_words (job_words),
        .job_pix   (job_pix)
    );

    assign dp_wr     = reg_wr && (reg_addr == ADDR_DATA);
    assign reg_ready = (reg_addr == ADDR_DATA) ? dp_ready : 1'b1;

    hx_unpack #(.CW(CW), .DW(DW), .CNTW(CNTW)) u_unpack (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .job_mono   (job_mono),
        .job_lg     (job_lg),
        .job_wm1    (job_wm1),
        .job_ox     (job_ox),
        .job_oy     (job_oy),
        .job_fg     (job_fg),
        .job_bg     (job_bg),
        .job_words  (job_words),
        .job_pix    (job_pix),
        .dp_wr      (dp_wr),
        .dp_data    (reg_wdata),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .dp_ready   (dp_ready),
        .push       (push),
        .push_x     (push_x),
        .push_y     (push_y),
        .push_color (push_color),
        .busy       (busy),
        .done       (done),
        .excess     (excess)
    );

    hx_pix_fifo #(.W(PW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({push_x, push_y, push_color}),
        .pop   (pix_ready),
        .dout  (fifo_out),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    assign pix_valid = !fifo_empty;
    assign pix_x     = fifo_out[PW-1 -: CW];
    assign pix_y     = fifo_out[DW +: CW];
    assign pix_color = fifo_out[DW-1:0];

endmodule

// File: rtl/hx_expander_chk.sv
module hx_expander_chk
    import hx_pkg::*;
#(
    parameter int CW = 12,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic          reg_ready,
    input logic          pix_valid,
    input logic          pix_ready,
    input logic [CW-1:0] pix_x,
    input logic [CW-1:0] pix_y,
    input logic [DW-1:0] pix_color,
    input logic          busy,
    input logic          done,
    input logic          excess
);

    // R1
    ctrl_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr != ADDR_DATA) |-> reg_ready);

    // R10
    hold_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_x) && $stable(pix_y) && $stable(pix_color)));

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    idle_no_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pix_valid);

    // R9
    idle_excess_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == ADDR_DATA) && !busy) |=> excess);

endmodule

bind hx_expander hx_expander_chk #(.CW(CW), .DW(DW)) u_chk (.*);

// File: tb/sim_hx_expander.sv
`timescale 1ns/1ps
module sim_hx_expander;

    localparam logic [2:0] A_CMD = 3'd0, A_SIZE = 3'd1, A_FG = 3'd2, A_BG = 3'd3,
                           A_FMT = 3'd4, A_ORG = 3'd5, A_DATA = 3'd6;
    localparam logic [31:0] CMD_MONO = 32'h0002_0142;  // bits 17, 8, 6, 1
    localparam logic [31:0] CMD_COPY = 32'h0000_0041;  // bits 6, 0

    typedef struct packed {
        logic        mono;
        logic [1:0]  fmt;
        logic [11:0] wm1;
        logic [11:0] hm1;
        logic [11:0] ox;
        logic [11:0] oy;
        logic [31:0] fg;
        logic [31:0] bg;
        logic [31:0] seed;
        logic        stall;
    } case_t;

    localparam int NCASE = 7;
    localparam case_t CASES [NCASE] = '{
        '{1'b1, 2'd0, 12'd4,  12'd2, 12'd10,   12'd20,   32'hAAAA0001, 32'h55550002, 32'hC3A55A3C, 1'b0},
        '{1'b1, 2'd0, 12'd39, 12'd1, 12'd100,  12'd7,    32'h00FF00FF, 32'h12345678, 32'h0F0F1234, 1'b1},
        '{1'b0, 2'd0, 12'd6,  12'd1, 12'd0,    12'd0,    32'h0,        32'h0,        32'h11223344, 1'b0},
        '{1'b0, 2'd1, 12'd2,  12'd2, 12'd5,    12'd6,    32'h0,        32'h0,        32'h8899AABB, 1'b1},
        '{1'b0, 2'd3, 12'd3,  12'd1, 12'd1,    12'd1,    32'h0,        32'h0,        32'hDEADBEEF, 1'b0},
        '{1'b1, 2'd0, 12'd0,  12'd0, 12'd50,   12'd60,   32'h00000077, 32'h00000088, 32'h80000000, 1'b0},
        '{1'b0, 2'd0, 12'd2,  12'd1, 12'd4094, 12'd4095, 32'h0,        32'h0,        32'h01020304, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic        reg_ready;
    logic        pix_valid;
    logic        pix_ready = 1'b0;
    logic [11:0] pix_x, pix_y;
    logic [31:0] pix_color;
    logic        busy, done, excess;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // current job, as the bench sees it
    logic        g_mono;
    int          g_lg, g_w, g_h, g_ox, g_oy;
    logic [31:0] g_fg, g_bg, g_seed;
    logic        g_stall;

    hx_expander u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ready(reg_ready), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y), .pix_color(pix_color),
        .busy(busy), .done(done), .excess(excess)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dword(input logic [31:0] seed, input int i);
        return seed ^ (32'(i) * 32'h9E3779B9);
    endfunction

    function automatic int npix();
        return g_w * g_h;
    endfunction

    function automatic int nwords();
        int b;
        b = g_mono ? 1 : (1 << g_lg);
        return (g_w * g_h * b + 3) / 4;
    endfunction

    function automatic logic [31:0] exp_color(input int k);
        logic [31:0] w;
        int ppw, lane;
        if (g_mono) begin
            w = dword(g_seed, k / 32);
            return w[31 - (k % 32)] ? g_fg : g_bg;
        end
        ppw  = 4 >> g_lg;
        w    = dword(g_seed, k / ppw);
        lane = k % ppw;
        w    = w >> (lane * (8 << g_lg));
        if (g_lg == 0) return {24'd0, w[7:0]};
        if (g_lg == 1) return {16'd0, w[15:0]};
        return w;
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        #1;
        reg_wr = 1'b1;
        reg_addr = a;
        reg_wdata = v;
        #1;
        while (!reg_ready) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    task automatic collect(input int n, input string req);
        int got = 0;
        int guard = 0;
        int ph = 0;
        logic pr;
        logic [11:0] ex, ey;
        while (got < n && guard < 20000) begin
            @(negedge clk);
            guard++;
            ph++;
            pr = g_stall ? ((ph % 3) == 1) : 1'b1;
            pix_ready = pr;
            if (pix_valid && pr) begin
                ex = 12'(g_ox + (got % g_w));
                ey = 12'(g_oy + (got / g_w));
                check(pix_color == exp_color(got), req, 64'(pix_color), 64'(exp_color(got)));
                check(pix_x == ex && pix_y == ey, "R5 coordinates", {40'd0, pix_x, pix_y}, {40'd0, ex, ey});
                got++;
            end
        end
        check(got == n, "R7 pixel count", 64'(got), 64'(n));
        @(negedge clk);
        pix_ready = 1'b0;
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int i = 0; i < 60 && !seen; i++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                check(!busy && !pix_valid, "R8 idle at done", {62'd0, busy, pix_valid}, 64'd0);
            end
        end
        check(seen, "R8 done pulse", 64'(seen), 64'd1);
        @(negedge clk);
        check(!done, "R8 done one cycle", 64'(done), 64'd0);
    endtask

    task automatic run_case(input case_t c);
        int nw;
        g_mono = c.mono;
        g_lg = (c.fmt == 2'd0) ? 0 : (c.fmt == 2'd1) ? 1 : 2;
        g_w = int'(c.wm1) + 1;
        g_h = int'(c.hm1) + 1;
        g_ox = int'(c.ox);
        g_oy = int'(c.oy);
        g_fg = c.fg;
        g_bg = c.bg;
        g_seed = c.seed;
        g_stall = c.stall;
        nw = nwords();
        wr_reg(A_SIZE, {4'd0, c.hm1, 4'd0, c.wm1});   // R6
        wr_reg(A_FG, c.fg);
        wr_reg(A_BG, c.bg);
        wr_reg(A_FMT, {30'd0, c.fmt});
        wr_reg(A_ORG, {4'd0, c.oy, 4'd0, c.ox});
        wr_reg(A_CMD, c.mono ? CMD_MONO : CMD_COPY);  // R2
        fork
            begin
                for (int i = 0; i < nw; i++) wr_reg(A_DATA, dword(c.seed, i));  // R7
            end
            begin
                collect(npix(), c.mono ? "R3 mono colour" : "R4 copy colour");
            end
        join
        wait_done();
    endtask

    initial begin
        // reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !excess && !pix_valid, "R1 reset outputs",
              {60'd0, busy, done, excess, pix_valid}, 64'd0);
        reg_addr = A_DATA;
        #1;
        check(reg_ready, "R1 data ready idle", 64'(reg_ready), 64'd1);

        // vector table
        for (int n = 0; n < NCASE; n++) run_case(CASES[n]);

        // R2: commands without host source or mode bits are ignored
        wr_reg(A_CMD, 32'h0002_0102);
        @(negedge clk);
        check(!busy, "R2 no host bit", 64'(busy), 64'd0);
        wr_reg(A_CMD, 32'h0000_0040);
        @(negedge clk);
        check(!busy, "R2 no mode bits", 64'(busy), 64'd0);

        // R9: idle data write is flagged and makes no pixel
        wr_reg(A_DATA, 32'hFFFF_FFFF);
        check(excess, "R9 idle excess", 64'(excess), 64'd1);
        @(negedge clk);
        check(!pix_valid && !busy, "R9 no pixel", {62'd0, pix_valid, busy}, 64'd0);

        // R10/R11/R12: stalled mono job, 8x1, word A5000000
        g_mono = 1'b1; g_lg = 0; g_w = 8; g_h = 1; g_ox = 3; g_oy = 9;
        g_fg = 32'h11; g_bg = 32'h22; g_seed = 32'hA500_0000; g_stall = 1'b0;
        pix_ready = 1'b0;
        wr_reg(A_SIZE, 32'h0000_0007);
        wr_reg(A_FG, 32'h11);
        wr_reg(A_BG, 32'h22);
        wr_reg(A_ORG, {4'd0, 12'd9, 4'd0, 12'd3});
        wr_reg(A_CMD, CMD_MONO);
        wr_reg(A_DATA, dword(g_seed, 0));
        repeat (10) @(negedge clk);
        check(pix_valid && pix_color == 32'h11 && pix_x == 12'd3, "R10 held pixel",
              {31'd0, pix_valid, pix_color}, {31'd0, 1'b1, 32'h11});
        wr_reg(A_CMD, CMD_COPY);          // R11
        wr_reg(A_FG, 32'h99);             // R12
        wr_reg(A_ORG, 32'h0);             // R12
        @(negedge clk);
        check(busy, "R11 still busy", 64'(busy), 64'd1);
        #1;
        reg_wr = 1'b1; reg_addr = A_DATA; reg_wdata = dword(g_seed, 1);
        #1;
        check(!reg_ready, "R10 data port refused", 64'(reg_ready), 64'd0);
        reg_wr = 1'b0;
        fork
            wr_reg(A_DATA, dword(g_seed, 1));
            collect(8, "R12 captured colours");
        join
        wait_done();
        wr_reg(A_DATA, 32'h1234_5678);
        check(excess, "R9 after done", 64'(excess), 64'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule